// File: doc/BRIEF.md
# Five-Level Locality Ownership Arbiter

This block decides which of five privilege levels (0 to 4) currently owns a shared secure device. Each level writes a four-bit action word through a single shared write port: ask for the device, give it back, take it by force from a lower level, or clear the platform established flag. The block keeps a queue of pending requesters, grants the device to exactly one of them at a time, and records on each level whether it lost the device to a forced takeover.

Software observes a shared state byte (valid, active level, assigned, established) and a per-level status pair (granted, been-seized). When the device is free, the highest-numbered pending level is granted on the next clock edge. A higher level may seize the device at any time, and the level that lost it keeps a sticky been-seized flag until it asks for the device again. Clearing the established flag is allowed only from levels 3 and 4.

Top module: `loc_arbiter`

## Requirements
- R1: `state_byte` holds valid at bit 7, the owning level at bits 4:2 (binary 0 to 4, and 000 when nobody owns the device), assigned at bit 1 and established at bit 0; bits 6:5 read 0.
- R2: At most one level reports granted (bit 2k of `loc_status` for level k), and assigned is 1 exactly when some level is granted.
- R3: Action bit 0 (request) from a non-owning level marks it pending; whenever the device is free and any level is pending, the highest-numbered pending level becomes owner on the next clock edge and is no longer pending.
- R4: Action bit 2 (seize) from a level numbered higher than the current owner makes the writer the owner on the next clock edge, with no free cycle in between.
- R5: A seize from a level numbered at or below the owner, or while the device is free, leaves ownership and the queue unchanged.
- R6: The level that loses the device to a seize reads been-seized (bit 2k+1 of `loc_status`) as 1; it stays 1 until that level writes a request, which clears it.
- R7: Action bit 1 (relinquish) from the owning level frees the device on the next clock edge; from any other level it does nothing.
- R8: Action bit 3 (reset-establishment) clears the established flag when written by level 3 or 4; the same bit from levels 0 to 2 leaves the flag unchanged.
- R9: During reset `state_byte` reads 8'h01 with `loc_status` all zero; valid rises on the first clock edge after reset is released.
- R10: A write naming a level of 5 or above has no effect on any output or on the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Action word is valid this cycle |
| wr_lvl | input | 3 | Level issuing the action |
| wr_act | input | 4 | Action bits: 0 request, 1 relinquish, 2 seize, 3 reset-establishment |
| state_byte | output | 8 | Shared state: valid, active level, assigned, established |
| loc_status | output | 10 | Per level k: bit 2k granted, bit 2k+1 been-seized |

## Verification
The bench builds the block with its default of five levels, privilege threshold 3 for the established flag and the flag set at reset, so every level encoding in the three-bit field and both sides of the privilege boundary are reachable. Level numbers up to 5 are driven, which exercises the out-of-range write path that a five-level build leaves in the three-bit level port. Random single-action writes keep the queue crowded, producing seizes over queued levels, grants after relinquish with several levels pending and repeated loss and recovery of been-seized.

// File: rtl/loc_pkg.sv
package loc_pkg;
  localparam int ACT_W = 4;
  localparam int ACT_REQ = 0;
  localparam int ACT_REL = 1;
  localparam int ACT_SEIZE = 2;
  localparam int ACT_RESEST = 3;
  localparam int LVL_FIELD_W = 3;

  function automatic logic [7:0] pack_state(input logic vld, input logic [LVL_FIELD_W-1:0] lvl,
                                            input logic asg, input logic est);
    return {vld, 2'b00, asg ? lvl : {LVL_FIELD_W{1'b0}}, asg, est};
  endfunction
endpackage

// File: rtl/loc_pick.sv
module loc_pick #(
  parameter int N = 5,
  localparam int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [LW-1:0] idx
);
  logic [N-1:0] above;
  logic [N-1:0] win;

  assign above[N-1] = 1'b0;
  genvar gi;
  generate
    for (gi = N - 2; gi >= 0; gi--) begin : g_above
      assign above[gi] = above[gi+1] | req[gi+1];
    end
    for (gi = 0; gi < N; gi++) begin : g_win
      assign win[gi] = req[gi] & ~above[gi];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (win[i]) idx = LW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/loc_seize_track.sv
module loc_seize_track #(
  parameter int N = 5,
  localparam int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [LW-1:0] set_lvl,
  input  logic          clr_en,
  input  logic [LW-1:0] clr_lvl,
  output logic [N-1:0]  seized
);
  genvar gk;
  generate
    for (gk = 0; gk < N; gk++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seized[gk] <= 1'b0;
        else if (set_en && set_lvl == LW'(gk)) seized[gk] <= 1'b1;
        else if (clr_en && clr_lvl == LW'(gk)) seized[gk] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/loc_estab.sv
module loc_estab #(
  parameter int LW = 3,
  parameter int PRIV_MIN = 3,
  parameter bit INIT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [LW-1:0] lvl,
  output logic          est,
  output logic          clr_ev
);
  assign clr_ev = hit && (int'(lvl) >= PRIV_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) est <= INIT;
    else if (clr_ev) est <= 1'b0;
  end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter #(
  parameter int N_LVL = 5,
  parameter int EST_MIN = 3,
  parameter bit EST_INIT = 1'b1,
  localparam int LW = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [LW-1:0]          wr_lvl,
  input  logic [loc_pkg::ACT_W-1:0] wr_act,
  output logic [7:0]             state_byte,
  output logic [2*N_LVL-1:0]     loc_status
);
  import loc_pkg::*;

  logic             valid_q;
  logic             own_vld_q;
  logic [LW-1:0]    own_q;
  logic [N_LVL-1:0] pend_q;
  logic [N_LVL-1:0] seized;
  logic             est;

  // internal events, named for the checker
  logic          wr_ok;
  logic          pend_any;
  logic [LW-1:0] pick_idx;
  logic          ev_grant;
  logic          ev_seize;
  logic          ev_release;
  logic          ev_est_clr;
  logic          is_owner_w;
  logic          req_set;

  function automatic logic [N_LVL-1:0] lvl_bit(input logic en, input logic [LW-1:0] l);
    logic [N_LVL-1:0] r;
    r = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (en && l == LW'(i)) r[i] = 1'b1;
    end
    return r;
  endfunction

  loc_pick #(.N(N_LVL)) u_pick (
    .req(pend_q), .any(pend_any), .idx(pick_idx)
  );

  assign wr_ok      = wr_en && (int'(wr_lvl) < N_LVL);
  assign is_owner_w = own_vld_q && (own_q == wr_lvl);
  assign ev_grant   = !own_vld_q && pend_any;
  assign ev_release = wr_ok && wr_act[ACT_REL] && is_owner_w;
  assign ev_seize   = wr_ok && wr_act[ACT_SEIZE] && own_vld_q && (wr_lvl > own_q);
  assign req_set    = wr_ok && wr_act[ACT_REQ] && !is_owner_w && !ev_seize &&
                      !(ev_grant && pick_idx == wr_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      own_vld_q <= 1'b0;
      own_q     <= '0;
      pend_q    <= '0;
    end else begin
      valid_q <= 1'b1;
      pend_q  <= (pend_q | lvl_bit(req_set, wr_lvl)) &
                 ~lvl_bit(ev_grant, pick_idx) & ~lvl_bit(ev_seize, wr_lvl);
      if (ev_seize) begin
        own_vld_q <= 1'b1;
        own_q     <= wr_lvl;
      end else if (ev_grant) begin
        own_vld_q <= 1'b1;
        own_q     <= pick_idx;
      end else if (ev_release) begin
        own_vld_q <= 1'b0;
      end
    end
  end

  loc_seize_track #(.N(N_LVL)) u_seized (
    .clk(clk), .rst_n(rst_n),
    .set_en(ev_seize), .set_lvl(own_q),
    .clr_en(wr_ok && wr_act[ACT_REQ]), .clr_lvl(wr_lvl),
    .seized(seized)
  );

  loc_estab #(.LW(LW), .PRIV_MIN(EST_MIN), .INIT(EST_INIT)) u_estab (
    .clk(clk), .rst_n(rst_n),
    .hit(wr_ok && wr_act[ACT_RESEST]), .lvl(wr_lvl),
    .est(est), .clr_ev(ev_est_clr)
  );

  assign state_byte = pack_state(valid_q, LVL_FIELD_W'(own_q), own_vld_q, est);

  genvar gk;
  generate
    for (gk = 0; gk < N_LVL; gk++) begin : g_stat
      assign loc_status[2*gk]   = own_vld_q && (own_q == LW'(gk));
      assign loc_status[2*gk+1] = seized[gk];
    end
  endgenerate
endmodule

// File: rtl/loc_arbiter_chk.sv
module loc_arbiter_chk #(
  parameter int N_LVL = 5,
  localparam int LW = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [LW-1:0]      wr_lvl,
  input logic [3:0]         wr_act,
  input logic [7:0]         state_byte,
  input logic [2*N_LVL-1:0] loc_status,
  input logic               pend_any,
  input logic               ev_seize
);
  logic [N_LVL-1:0] granted;
  logic [N_LVL-1:0] lost;
  logic             asg;
  logic [2:0]       act_lvl;

  always_comb begin
    for (int i = 0; i < N_LVL; i++) begin
      granted[i] = loc_status[2*i];
      lost[i]    = loc_status[2*i+1];
    end
  end
  assign asg     = state_byte[1];
  assign act_lvl = state_byte[4:2];

  // R1
  level_zero_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !asg |-> (act_lvl == 3'd0 && state_byte[6:5] == 2'b00));

  // R2
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(granted) && (asg == (|granted)));

  // R3
  free_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!asg && pend_any) |=> asg);

  // R4
  seize_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_act[2] && asg && int'(wr_lvl) < N_LVL && 3'(wr_lvl) > act_lvl)
      |=> (asg && act_lvl == $past(3'(wr_lvl))));

  // R5
  seize_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_act == 4'b0100 && asg && 3'(wr_lvl) <= act_lvl)
      |=> (asg && $stable(act_lvl)));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_act[1] && !wr_act[2] && asg && 3'(wr_lvl) == act_lvl) |=> !asg);

  // R8
  est_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_act[3] && wr_lvl < LW'(3)) |=> $stable(state_byte[0]));

  // R8
  est_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_act[3] && int'(wr_lvl) >= 3 && int'(wr_lvl) < N_LVL) |=> !state_byte[0]);

  genvar gk;
  generate
    for (gk = 0; gk < N_LVL; gk++) begin : g_lost
      // R6
      lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_seize && granted[gk]) |=> lost[gk]);
      // R6
      lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost[gk] && !(wr_en && wr_act[0] && wr_lvl == LW'(gk))) |=> lost[gk]);
    end
  endgenerate
endmodule

bind loc_arbiter loc_arbiter_chk #(.N_LVL(N_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lvl(wr_lvl), .wr_act(wr_act),
  .state_byte(state_byte), .loc_status(loc_status),
  .pend_any(pend_any), .ev_seize(ev_seize)
);

// File: tb/test_loc_arbiter.sv
module test_loc_arbiter;
  localparam int N = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_lvl = '0;
  logic [3:0] wr_act = '0;
  logic [7:0] state_byte;
  logic [9:0] loc_status;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench reference state
  bit       m_vld, m_ov, m_est;
  int       m_own;
  bit [4:0] m_pend, m_lost;

  always #10 clk = ~clk;

  loc_arbiter i_loc_arbiter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lvl(wr_lvl), .wr_act(wr_act),
    .state_byte(state_byte), .loc_status(loc_status)
  );

  function automatic int top_pending(input bit [4:0] p);
    for (int i = 4; i >= 0; i--) if (p[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] exp_state();
    return {m_vld, 2'b00, m_ov ? 3'(m_own) : 3'd0, m_ov, m_est};
  endfunction

  function automatic logic [9:0] exp_status();
    logic [9:0] s = '0;
    for (int i = 0; i < N; i++) begin
      s[2*i]   = m_ov && m_own == i;
      s[2*i+1] = m_lost[i];
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(input string req);
    check(state_byte == exp_state(), req, 32'(state_byte), 32'(exp_state()));
    check(loc_status == exp_status(), req, 32'(loc_status), 32'(exp_status()));
  endtask

  task automatic model_reset();
    m_vld = 0; m_ov = 0; m_est = 1; m_own = 0; m_pend = '0; m_lost = '0;
  endtask

  // reference update from the requirements for one clock edge
  task automatic model_edge(input bit en, input int l, input bit [3:0] a);
    bit ok = en && l < N;
    int hi = top_pending(m_pend);
    bit grant = !m_ov && hi >= 0;
    bit owner_w = m_ov && m_own == l;
    bit take = ok && a[2] && m_ov && l > m_own;
    bit rel = ok && a[1] && owner_w;
    bit [4:0] np = m_pend;
    if (ok && a[0] && !owner_w && !take && !(grant && hi == l)) np[l] = 1;
    if (grant) np[hi] = 0;
    if (take) np[l] = 0;
    if (take) m_lost[m_own] = 1;
    else if (ok && a[0]) m_lost[l] = 0;
    if (ok && a[0] && take) m_lost[l] = 0;
    if (ok && a[3] && l >= 3) m_est = 0;
    if (take) m_own = l;
    else if (grant) begin m_ov = 1; m_own = hi; end
    else if (rel) m_ov = 0;
    m_pend = np;
    m_vld = 1;
  endtask

  task automatic step(input bit en, input int l, input bit [3:0] a, input string req);
    wr_en = en; wr_lvl = 3'(l); wr_act = a;
    @(posedge clk);
    model_edge(en, l, a);
    @(negedge clk);
    compare(req);
    wr_en = 0; wr_act = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'd4711);
    model_reset();
    repeat (2) @(negedge clk);
    // R9 reset values
    check(state_byte == 8'h01, "R9", 32'(state_byte), 32'h01);
    check(loc_status == '0, "R9", 32'(loc_status), 32'h0);
    rst_n = 1'b1;
    @(posedge clk); m_vld = 1; @(negedge clk);
    check(state_byte == 8'h81, "R9", 32'(state_byte), 32'h81);

    // R3 request while free, then grant on the next edge
    step(1, 1, 4'b0001, "R3");
    step(0, 0, 4'b0000, "R3");
    check(state_byte == 8'h87, "R3", 32'(state_byte), 32'h87);
    step(1, 0, 4'b0001, "R3");
    step(1, 2, 4'b0001, "R3");
    // R5 lower seize ignored
    step(1, 0, 4'b0100, "R5");
    step(1, 1, 4'b0100, "R5");
    check(state_byte[4:2] == 3'd1, "R5", 32'(state_byte), 32'h87);
    // R4 R6 higher seize
    step(1, 3, 4'b0100, "R4");
    check(state_byte == 8'h8f, "R4", 32'(state_byte), 32'h8f);
    check(loc_status[3] == 1'b1, "R6", 32'(loc_status), 32'h8);
    // R7 relinquish from non-owner then owner
    step(1, 1, 4'b0010, "R7");
    check(state_byte == 8'h8f, "R7", 32'(state_byte), 32'h8f);
    step(1, 3, 4'b0010, "R7");
    check(state_byte == 8'h81, "R7", 32'(state_byte), 32'h81);
    // R3 highest pending (2 over 0) next
    step(0, 0, 4'b0000, "R3");
    check(state_byte == 8'h8b, "R3", 32'(state_byte), 32'h8b);
    // R6 sticky, then cleared by request
    step(1, 4, 4'b0001, "R6");
    check(loc_status[3] == 1'b1, "R6", 32'(loc_status), 32'h8);
    step(1, 1, 4'b0001, "R6");
    check(loc_status[3] == 1'b0, "R6", 32'(loc_status), 32'h0);
    // R10 out-of-range level
    step(1, 5, 4'b0100, "R10");
    step(1, 5, 4'b1001, "R10");
    check(state_byte == 8'h8b, "R10", 32'(state_byte), 32'h8b);
    // R8 privilege on established flag
    step(1, 2, 4'b1000, "R8");
    check(state_byte[0] == 1'b1, "R8", 32'(state_byte), 32'h1);
    step(1, 4, 4'b1000, "R8");
    check(state_byte[0] == 1'b0, "R8", 32'(state_byte), 32'h0);

    // R1 R2 random mix against the reference
    for (int n = 0; n < 4000; n++) begin
      bit en = ($urandom % 4) != 0;
      int l = int'($urandom % 6);
      bit [3:0] a = 4'(1 << ($urandom % 4));
      if (($urandom % 200) == 0) begin
        rst_n = 0; model_reset();
        @(negedge clk);
        compare("R9");
        rst_n = 1;
        @(posedge clk); m_vld = 1; @(negedge clk);
      end
      step(en, l, a, (n % 2) ? "R1" : "R2");
    end
    if (seed == 0) $display("seed zero");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule